// File: doc/BRIEF.md
# Level Interrupt State Tracker

This block follows one level-sensitive interrupt line inside an interrupt controller. It keeps that line in one of four states: Inactive, Pending, Active, or Active-and-Pending. The source level first passes through a synchroniser. Two one-cycle command pulses drive the rest of the state machine. The acknowledge pulse comes from a CPU read of the acknowledge register. The deactivate pulse comes from a CPU write to the deactivate register.

Pending status always follows the synchronised level. This leads to a race. Suppose a handler deactivates the interrupt before the drop of the source level has crossed the synchroniser. The tracker then falls back to Pending for a short time and raises its request line again. That request is a spurious interrupt. Software can avoid it by polling the pending readback bit until the bit clears, and only then issuing the deactivate.

The outputs are the raw state, a pending bit for a status register, and a request line to the CPU interface.

Top module: `lvl_irq_tracker`

## Requirements
- R1: While reset is asserted, and after it is released, the state is Inactive. In that state `state_o` = 2'b00, `pend_o` = 0 and `irq_req_o` = 0. The state encoding is: Pending = 2'b01, Active = 2'b10, Active-and-Pending = 2'b11.
- R2: In Inactive, a high synchronised level moves the state to Pending.
- R3: In Pending, an acknowledge while the synchronised level is high moves the state to Active-and-Pending.
- R4: In Active-and-Pending, a low synchronised level with no deactivate moves the state to Active.
- R5: In Active, a deactivate moves the state to Inactive if the synchronised level is low. It moves the state to Pending if the level is high.
- R6: In Active-and-Pending, a deactivate while the synchronised level is still high moves the state to Pending, and the request line rises again.
- R7: In Pending, a low synchronised level moves the state to Inactive. No acknowledge is needed, and an acknowledge in the same cycle does not change this.
- R8: A change on `irq_lvl_i` reaches the state machine through two flops. The state changes on the third rising edge after the change is set up, and not earlier.
- R9: `irq_req_o` is 1 only in Pending. `pend_o` is 1 in Pending and in Active-and-Pending, and 0 otherwise.
- R10: An acknowledge outside Pending has no effect. A deactivate in Inactive or in Pending has no effect.
- R11: In Active-and-Pending, a deactivate in the same cycle as a low synchronised level moves the state straight to Inactive.
- R12: In Active, a high synchronised level with no deactivate moves the state to Active-and-Pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lvl_i | input | 1 | Interrupt source level, asynchronous to the clock |
| ack_i | input | 1 | One-cycle acknowledge pulse |
| deact_i | input | 1 | One-cycle deactivate pulse |
| state_o | output | 2 | Current state, {active, pending} |
| pend_o | output | 1 | Pending readback for the status register |
| irq_req_o | output | 1 | Interrupt request to the CPU interface |

## Verification
A wrong transition shows up on `state_o` on the falling edge just after the rising edge that caused it. Because the bench compares every cycle, the error is reported within half a clock. A wrong encoding or wrong output decode shows on `pend_o` or `irq_req_o` in the same cycle. A synchroniser that is one flop too short or too long moves every level-driven transition by one cycle. The directed checks on latency catch this, and so does the per-cycle model. The deactivate-overtakes-drop race is checked in two ways: the state must pass through Pending with the request raised, and then return to Inactive exactly when the level drop arrives.

// File: rtl/lit_pkg.sv
package lit_pkg;
  // bit0 = pending, bit1 = active
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_PEND  = 2'b01,
    ST_ACT   = 2'b10,
    ST_APEND = 2'b11
  } lit_state_e;
endpackage

// File: rtl/lit_sync.sv
module lit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lit_fsm.sv
module lit_fsm
  import lit_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic       ack_i,
  input  logic       deact_i,
  output lit_state_e state_o
);
  lit_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (lvl_i) st_d = ST_PEND;
      ST_PEND: begin
        if (!lvl_i)     st_d = ST_IDLE;
        else if (ack_i) st_d = ST_APEND;
      end
      // deactivate wins; pending then follows the seen level
      ST_APEND: begin
        if (deact_i)     st_d = lvl_i ? ST_PEND : ST_IDLE;
        else if (!lvl_i) st_d = ST_ACT;
      end
      ST_ACT: begin
        if (deact_i)    st_d = lvl_i ? ST_PEND : ST_IDLE;
        else if (lvl_i) st_d = ST_APEND;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/lit_decode.sv
module lit_decode
  import lit_pkg::*;
(
  input  lit_state_e st_i,
  output logic       pend_o,
  output logic       req_o
);
  always_comb begin
    pend_o = 1'b0;
    req_o  = 1'b0;
    unique case (st_i)
      ST_PEND:  begin pend_o = 1'b1; req_o = 1'b1; end
      ST_APEND: pend_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/lvl_irq_tracker.sv
module lvl_irq_tracker #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       irq_lvl_i,
  input  logic       ack_i,
  input  logic       deact_i,
  output logic [1:0] state_o,
  output logic       pend_o,
  output logic       irq_req_o
);
  import lit_pkg::*;

  logic       lvl_sync;
  lit_state_e st;

  lit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_lvl_i),
    .q_o   (lvl_sync)
  );

  lit_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl_sync),
    .ack_i  (ack_i),
    .deact_i(deact_i),
    .state_o(st)
  );

  lit_decode u_dec (
    .st_i  (st),
    .pend_o(pend_o),
    .req_o (irq_req_o)
  );

  assign state_o = st;
endmodule

// File: rtl/lit_checker.sv
module lit_checker
  import lit_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       lvl_s,
  input logic       ack_i,
  input logic       deact_i,
  input logic [1:0] state_o,
  input logic       pend_o,
  input logic       irq_req_o
);
  AST_IDLE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IDLE && lvl_s) |=> state_o == ST_PEND); // R2
  AST_ACK_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_PEND && lvl_s && ack_i) |=> state_o == ST_APEND); // R3
  AST_APEND_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_APEND && !lvl_s && !deact_i) |=> state_o == ST_ACT); // R4
  AST_ACT_DEACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_ACT && deact_i && !lvl_s) |=> state_o == ST_IDLE); // R5
  AST_RACE_REPEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_APEND && deact_i && lvl_s) |=> (state_o == ST_PEND && irq_req_o)); // R6
  AST_PEND_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_PEND && !lvl_s) |=> state_o == ST_IDLE); // R7
  AST_NO_REQ_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o[1] |-> !irq_req_o); // R9
  AST_REQ_HAS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> pend_o); // R9
  AST_DEACT_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_IDLE && !lvl_s && (deact_i || ack_i)) |=> state_o == ST_IDLE); // R10
  AST_BOTH_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_APEND && deact_i && !lvl_s) |=> state_o == ST_IDLE); // R11
  AST_ACT_RERISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_ACT && lvl_s && !deact_i) |=> state_o == ST_APEND); // R12
endmodule

bind lvl_irq_tracker lit_checker u_lit_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .lvl_s    (lvl_sync),
  .ack_i    (ack_i),
  .deact_i  (deact_i),
  .state_o  (state_o),
  .pend_o   (pend_o),
  .irq_req_o(irq_req_o)
);

// File: tb/lvl_irq_tracker_bench.sv
module lvl_irq_tracker_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       irq_lvl_i = 1'b0;
  logic       ack_i = 1'b0;
  logic       deact_i = 1'b0;
  logic [1:0] state_o;
  logic       pend_o;
  logic       irq_req_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  string cur_req = "R1";

  // reference: 0 idle, 1 pending, 2 active, 3 active+pending
  int m_st = 0;
  int m_hist[$] = '{0, 0};

  always #4 clk_i = ~clk_i;

  lvl_irq_tracker u_lvl_irq_tracker (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_lvl_i(irq_lvl_i),
    .ack_i    (ack_i),
    .deact_i  (deact_i),
    .state_o  (state_o),
    .pend_o   (pend_o),
    .irq_req_o(irq_req_o)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_st = 0;
      m_hist = '{0, 0};
    end else begin
      int seen;
      int nxt;
      seen = m_hist[1];
      nxt = m_st;
      if (m_st == 0) begin
        if (seen == 1) nxt = 1;
      end else if (m_st == 1) begin
        if (seen == 0) nxt = 0;
        else if (ack_i) nxt = 3;
      end else begin
        if (deact_i) nxt = seen;
        else if (m_st == 3 && seen == 0) nxt = 2;
        else if (m_st == 2 && seen == 1) nxt = 3;
      end
      m_st = nxt;
      m_hist.push_front(int'(irq_lvl_i));
      void'(m_hist.pop_back());
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      int exp_p;
      int exp_r;
      exp_p = (m_st == 1 || m_st == 3) ? 1 : 0;
      exp_r = (m_st == 1) ? 1 : 0;
      total++;
      if (int'(state_o) != m_st || int'(pend_o) != exp_p || int'(irq_req_o) != exp_r) begin
        bad++;
        $display("FAIL %s model: state=%0d pend=%0b req=%0b expected state=%0d pend=%0d req=%0d",
                 cur_req, state_o, pend_o, irq_req_o, m_st, exp_p, exp_r);
      end
    end
  end

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(string req, int exp_st);
    int exp_p;
    int exp_r;
    exp_p = (exp_st == 1 || exp_st == 3) ? 1 : 0;
    exp_r = (exp_st == 1) ? 1 : 0;
    total++;
    if (int'(state_o) != exp_st || int'(pend_o) != exp_p || int'(irq_req_o) != exp_r) begin
      bad++;
      $display("FAIL %s: state=%0d pend=%0b req=%0b expected state=%0d pend=%0d req=%0d",
               req, state_o, pend_o, irq_req_o, exp_st, exp_p, exp_r);
    end
  endtask

  task automatic pulse_ack();
    ack_i = 1'b1; step(); ack_i = 1'b0;
  endtask

  task automatic pulse_deact();
    deact_i = 1'b1; step(); deact_i = 1'b0;
  endtask

  initial begin
    #1200000;
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 in reset", 0);
    rst_ni = 1'b1;
    step();
    chk("R1 after reset", 0);

    cur_req = "R2/R8";
    irq_lvl_i = 1'b1;
    step(); chk("R8 one edge", 0);
    step(); chk("R8 two edges", 0);
    step(); chk("R2 R9 pending", 1);

    cur_req = "R3";
    pulse_ack(); chk("R3 R9 ack", 3);
    pulse_ack(); chk("R10 ack in act+pend", 3);

    cur_req = "R4";
    irq_lvl_i = 1'b0;
    step(); step(); chk("R8 drop not yet seen", 3);
    step(); chk("R4 drop", 2);
    pulse_ack(); chk("R10 ack in active", 2);

    cur_req = "R5";
    pulse_deact(); chk("R5 deact low", 0);
    pulse_deact(); chk("R10 deact in idle", 0);
    pulse_ack(); chk("R10 ack in idle", 0);

    cur_req = "R10";
    irq_lvl_i = 1'b1;
    step(); step(); step(); chk("R2 pending again", 1);
    pulse_deact(); chk("R10 deact in pending", 1);

    cur_req = "R6";
    pulse_ack(); chk("R3 ack", 3);
    irq_lvl_i = 1'b0;
    pulse_deact(); chk("R6 race repend", 1);
    step(); chk("R6 still pending", 1);
    step(); chk("R7 drop clears pending", 0);

    cur_req = "R7";
    irq_lvl_i = 1'b1;
    step(); step(); step(); chk("R2", 1);
    irq_lvl_i = 1'b0;
    step(); step();
    ack_i = 1'b1; step(); ack_i = 1'b0;
    chk("R7 drop beats ack", 0);

    cur_req = "R11";
    irq_lvl_i = 1'b1;
    step(); step(); step();
    pulse_ack(); chk("R3", 3);
    irq_lvl_i = 1'b0;
    step(); step(); chk("R11 pre", 3);
    pulse_deact(); chk("R11 both same cycle", 0);

    cur_req = "R12";
    irq_lvl_i = 1'b1;
    step(); step(); step();
    pulse_ack();
    irq_lvl_i = 1'b0;
    step(); step(); step(); chk("R4", 2);
    irq_lvl_i = 1'b1;
    step(); step(); step(); chk("R12 rerise", 3);
    irq_lvl_i = 1'b0;
    step(); step(); step(); chk("R4", 2);
    irq_lvl_i = 1'b1;
    step(); step(); chk("R5 pre", 2);
    pulse_deact(); chk("R5 deact high", 1);

    cur_req = "R2 R3 R4 R5 R6 R7 R11 R12 random";
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 5) == 0) irq_lvl_i = ~irq_lvl_i;
      ack_i   = ($urandom_range(0, 3) == 0);
      deact_i = ($urandom_range(0, 3) == 0);
      step();
    end
    ack_i = 1'b0;
    deact_i = 1'b0;
    step();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule